// File: doc/BRIEF.md
# ADSR Envelope Generator

This block produces the 8-bit amplitude envelope of one synthesizer voice. Software sets the envelope shape with two byte writes. One write carries the attack and decay rates, the other the sustain level and the release rate. A third write carries the gate bit, which starts and ends a note. A rising gate ramps the level up linearly to full scale. The level then falls toward the sustain level and holds there while the gate stays high. A falling gate lets the level fall to zero.

Every step of the envelope is paced by a free-running 16-bit prescaler. It compares against one of sixteen fixed periods, chosen by the rate nibble of the current phase. The falling phases add a second divider whose ratio depends on the present level. This bends the straight decrement into a piecewise approximation of an exponential decay. Gate writes never clear the prescaler, so the first step after a gate change can come late. A larger period can also be replaced by a smaller one after the count has already passed it. The counter then runs through its full 16-bit range before the next step.

Top module: `adsr_env_core`

## Requirements
- R1: The 16-bit prescaler advances by one each clock. When its incremented value equals the selected period, it reports a step opportunity and restarts from 0. It wraps from 0xFFFF to 0 and is never cleared by gate or register writes.
- R2: Rate nibble n selects period P(n), in clocks: 0→9, 1→32, 2→63, 3→95, 4→149, 5→220, 6→267, 7→313, 8→392, 9→977, 10→1954, 11→3126, 12→3907, 13→11720, 14→19532, 15→31251. The rate nibble used is the attack rate in attack, the decay rate in decay-sustain and the release rate in release.
- R3: The level moves only on an envelope step. In decay-sustain and release, a step needs that many opportunities, set by a divisor that depends on the current level:
  - level 0: divisor 1
  - levels 1 to 6: divisor 30
  - levels 7 to 14: divisor 16
  - levels 15 to 26: divisor 8
  - levels 27 to 54: divisor 4
  - levels 55 to 93: divisor 2
  - levels above 93: divisor 1
- R4: In attack, every opportunity is a step and the level rises by 1. On reaching 0xFF the phase becomes decay-sustain.
- R5: In decay-sustain, each step lowers the level by 1 unless the level equals the sustain target, in which case it holds. The sustain target is the sustain nibble repeated in both halves of the byte.
- R6: In release, each step lowers the level by 1 down to 0. At 0 a hold lock is set and the level stays frozen until the next rising gate.
- R7: A control write takes the gate from bit 0 and ignores bits 7:1. A 0→1 change enters attack. A 1→0 change enters release. Writing the same gate value has no effect.
- R8: An attack/decay write (attack in bits 7:4, decay in bits 3:0) changes the period in use from the next clock if the block is in attack or decay-sustain.
- R9: A sustain/release write stores sustain from bits 7:4 and release from bits 3:0. A new release rate takes effect from the next clock if the block is in release.
- R10: Synchronous reset clears the level, all four settings, the gate, the prescaler and the divider. It selects release with the hold lock set.
- R11: When a gate write and a step fall on the same clock, the level follows the old phase's step. The phase and the hold lock follow the gate edge, so a rising gate always leaves the lock clear.
- R12: Any falling step that lands on or stays at level 0 sets the hold lock. This includes decay with sustain 0 while the gate is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_ctl | input | 1 | Control write strobe (gate in bit 0) |
| wr_ad | input | 1 | Attack/decay write strobe |
| wr_sr | input | 1 | Sustain/release write strobe |
| wr_data | input | 8 | Write data shared by the three strobes |
| env_level | output | 8 | Current envelope level |

## Verification
The envelope step and a gate write can land on the same clock. The bench provokes both directions. It uses its own cycle model to find the clock on which a step is due, and it drops the gate on exactly that clock during attack. It raises the gate on exactly the clock where release would take the level from 1 to 0. It then judges that the level shows the old phase's step on that clock. It also judges that the following steps run in the new direction: a decrement after the drop, and a fresh increment after the raise, which shows the hold lock was not left set.

// File: rtl/adsr_env_pkg.sv
package adsr_env_pkg;

  localparam int LVL_W  = 8;
  localparam int RATE_W = 4;
  localparam int PER_W  = 16;
  localparam int EXP_W  = 5;

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_RELEASE = 2'd2
  } phase_e;

  // Clocks between step opportunities for each rate nibble.
  function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] sel);
    logic [PER_W-1:0] p;
    case (sel)
      4'd0:    p = 16'd9;
      4'd1:    p = 16'd32;
      4'd2:    p = 16'd63;
      4'd3:    p = 16'd95;
      4'd4:    p = 16'd149;
      4'd5:    p = 16'd220;
      4'd6:    p = 16'd267;
      4'd7:    p = 16'd313;
      4'd8:    p = 16'd392;
      4'd9:    p = 16'd977;
      4'd10:   p = 16'd1954;
      4'd11:   p = 16'd3126;
      4'd12:   p = 16'd3907;
      4'd13:   p = 16'd11720;
      4'd14:   p = 16'd19532;
      default: p = 16'd31251;
    endcase
    return p;
  endfunction

  // Level-dependent extra division applied while the level falls.
  function automatic logic [EXP_W-1:0] exp_divisor(input logic [LVL_W-1:0] lvl);
    logic [EXP_W-1:0] d;
    if (lvl > 8'd93)       d = 5'd1;
    else if (lvl >= 8'd55) d = 5'd2;
    else if (lvl >= 8'd27) d = 5'd4;
    else if (lvl >= 8'd15) d = 5'd8;
    else if (lvl >= 8'd7)  d = 5'd16;
    else if (lvl >= 8'd1)  d = 5'd30;
    else                   d = 5'd1;
    return d;
  endfunction

  // Sustain nibble repeated into both halves of the level byte.
  function automatic logic [LVL_W-1:0] sustain_target(input logic [RATE_W-1:0] s);
    return {s, s};
  endfunction

endpackage

// File: rtl/adsr_rate_regs.sv
module adsr_rate_regs
  import adsr_env_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ad,
  input  logic          wr_sr,
  input  logic [2*RW-1:0] wr_data,
  output logic [RW-1:0] att_rate,
  output logic [RW-1:0] dec_rate,
  output logic [RW-1:0] sus_nib,
  output logic [RW-1:0] rel_rate
);

  always_ff @(posedge clk) begin
    if (rst) begin
      att_rate <= '0;
      dec_rate <= '0;
      sus_nib  <= '0;
      rel_rate <= '0;
    end else begin
      if (wr_ad) begin
        att_rate <= wr_data[2*RW-1:RW];
        dec_rate <= wr_data[RW-1:0];
      end
      if (wr_sr) begin
        sus_nib  <= wr_data[2*RW-1:RW];
        rel_rate <= wr_data[RW-1:0];
      end
    end
  end

endmodule

// File: rtl/adsr_rate_prescaler.sv
module adsr_rate_prescaler
  import adsr_env_pkg::*;
#(
  parameter int CW = PER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic          rate_hit
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc  = cnt_q + ONE;
  assign rate_hit = (cnt_inc == period);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (rate_hit) cnt_q <= '0;
    else               cnt_q <= cnt_inc;
  end

  a_r1_restart_after_hit: assert property (@(posedge clk) disable iff (rst)
    rate_hit |=> (cnt_q == '0));

  a_r1_no_early_zero: assert property (@(posedge clk) disable iff (rst)
    (!rate_hit && cnt_q != {CW{1'b1}}) |=> (cnt_q != '0));

endmodule

// File: rtl/adsr_exp_divider.sv
module adsr_exp_divider
  import adsr_env_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int EW = EXP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_hit,
  input  logic          bypass,
  input  logic [LW-1:0] level,
  output logic          step_ok
);

  localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

  logic [EW-1:0] div;
  logic [EW-1:0] cnt_q;
  logic [EW-1:0] cnt_inc;
  logic          div_wrap;

  assign div      = exp_divisor(level);
  assign cnt_inc  = cnt_q + ONE;
  assign div_wrap = (cnt_inc == div);
  assign step_ok  = rate_hit && (bypass || div_wrap);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (step_ok)  cnt_q <= '0;
    else if (rate_hit) cnt_q <= cnt_inc;
  end

  a_r3_count_below_divisor: assert property (@(posedge clk) disable iff (rst)
    cnt_q < div);

  a_r4_attack_clears_divider: assert property (@(posedge clk) disable iff (rst)
    (bypass && rate_hit) |=> (cnt_q == '0));

  a_r3_idle_without_hit: assert property (@(posedge clk) disable iff (rst)
    !rate_hit |=> $stable(cnt_q));

endmodule

// File: rtl/adsr_phase_fsm.sv
module adsr_phase_fsm
  import adsr_env_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic          gate_bit,
  input  logic          step_ok,
  input  logic [RW-1:0] att_rate,
  input  logic [RW-1:0] dec_rate,
  input  logic [RW-1:0] sus_nib,
  input  logic [RW-1:0] rel_rate,
  output logic [LW-1:0] level,
  output phase_e        phase,
  output logic [RW-1:0] rate_sel,
  output logic          step_do,
  output logic          gate_rise,
  output logic          gate_fall
);

  localparam logic [LW-1:0] LVL_MAX = {LW{1'b1}};
  localparam logic [LW-1:0] LVL_ONE = {{(LW-1){1'b0}}, 1'b1};

  logic          gate_q;
  logic          hold_q;
  logic [LW-1:0] level_q;
  phase_e        phase_q;

  logic [LW-1:0] level_n;
  phase_e        phase_step;
  phase_e        phase_n;
  logic          hold_step;
  logic          hold_n;
  logic [LW-1:0] sus_tgt;
  logic          at_sustain;

  assign gate_rise  = ctl_we &&  gate_bit && !gate_q;
  assign gate_fall  = ctl_we && !gate_bit &&  gate_q;
  assign step_do    = step_ok && !hold_q;
  assign sus_tgt    = sustain_target(sus_nib);
  assign at_sustain = (phase_q == PH_DECAY) && (level_q == sus_tgt);

  always_comb begin
    case (phase_q)
      PH_ATTACK: rate_sel = att_rate;
      PH_DECAY:  rate_sel = dec_rate;
      default:   rate_sel = rel_rate;
    endcase
  end

  always_comb begin
    level_n    = level_q;
    phase_step = phase_q;
    hold_step  = hold_q;
    if (step_do) begin
      if (phase_q == PH_ATTACK) begin
        if (level_q != LVL_MAX) level_n = level_q + LVL_ONE;
        if (level_n == LVL_MAX) phase_step = PH_DECAY;
      end else if (level_q == '0) begin
        hold_step = 1'b1;
      end else if (!at_sustain) begin
        level_n = level_q - LVL_ONE;
        if (level_n == '0) hold_step = 1'b1;
      end
    end
    if (gate_rise) begin
      phase_n = PH_ATTACK;
      hold_n  = 1'b0;
    end else if (gate_fall) begin
      phase_n = PH_RELEASE;
      hold_n  = hold_step;
    end else begin
      phase_n = phase_step;
      hold_n  = hold_step;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      hold_q  <= 1'b1;
      level_q <= '0;
      phase_q <= PH_RELEASE;
    end else begin
      if (ctl_we) gate_q <= gate_bit;
      hold_q  <= hold_n;
      level_q <= level_n;
      phase_q <= phase_n;
    end
  end

  assign level = level_q;
  assign phase = phase_q;

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (level_q == '0 && hold_q && phase_q == PH_RELEASE));

  a_r3_level_moves_on_step_only: assert property (@(posedge clk) disable iff (rst)
    !step_do |=> $stable(level_q));

  a_r4_attack_increments: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ATTACK && step_do && level_q != LVL_MAX)
      |=> (level_q == $past(level_q) + LVL_ONE));

  a_r5_sustain_holds: assert property (@(posedge clk) disable iff (rst)
    (at_sustain && level_q != '0) |=> $stable(level_q));

  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !gate_rise) |=> $stable(level_q));

  a_r7_fall_enters_release: assert property (@(posedge clk) disable iff (rst)
    gate_fall |=> (phase_q == PH_RELEASE));

  a_r11_rise_wins: assert property (@(posedge clk) disable iff (rst)
    gate_rise |=> (phase_q == PH_ATTACK && !hold_q));

  a_r12_zero_locks: assert property (@(posedge clk) disable iff (rst)
    (step_do && phase_q != PH_ATTACK && level_q == LVL_ONE && !at_sustain && !gate_rise)
      |=> hold_q);

endmodule

// File: rtl/adsr_env_core.sv
module adsr_env_core
  import adsr_env_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int RW = RATE_W,
  parameter int CW = PER_W,
  parameter int EW = EXP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic          wr_ad,
  input  logic          wr_sr,
  input  logic [7:0]    wr_data,
  output logic [LW-1:0] env_level
);

  logic [RW-1:0] att_rate;
  logic [RW-1:0] dec_rate;
  logic [RW-1:0] sus_nib;
  logic [RW-1:0] rel_rate;
  logic [RW-1:0] rate_sel;
  logic [CW-1:0] period;
  logic          rate_hit;
  logic          step_ok;
  logic          step_do;
  logic          gate_rise;
  logic          gate_fall;
  phase_e        phase;

  adsr_rate_regs #(.RW(RW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ad    (wr_ad),
    .wr_sr    (wr_sr),
    .wr_data  (wr_data),
    .att_rate (att_rate),
    .dec_rate (dec_rate),
    .sus_nib  (sus_nib),
    .rel_rate (rel_rate)
  );

  assign period = rate_period(rate_sel);

  adsr_rate_prescaler #(.CW(CW)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .period   (period),
    .rate_hit (rate_hit)
  );

  adsr_exp_divider #(.LW(LW), .EW(EW)) u_expdiv (
    .clk      (clk),
    .rst      (rst),
    .rate_hit (rate_hit),
    .bypass   (phase == PH_ATTACK),
    .level    (env_level),
    .step_ok  (step_ok)
  );

  adsr_phase_fsm #(.LW(LW), .RW(RW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (wr_ctl),
    .gate_bit  (wr_data[0]),
    .step_ok   (step_ok),
    .att_rate  (att_rate),
    .dec_rate  (dec_rate),
    .sus_nib   (sus_nib),
    .rel_rate  (rel_rate),
    .level     (env_level),
    .phase     (phase),
    .rate_sel  (rate_sel),
    .step_do   (step_do),
    .gate_rise (gate_rise),
    .gate_fall (gate_fall)
  );

  a_r3_step_needs_opportunity: assert property (@(posedge clk) disable iff (rst)
    step_do |-> rate_hit);

endmodule

// File: tb/adsr_env_core_test.sv
module adsr_env_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_ctl = 1'b0;
  logic       wr_ad = 1'b0;
  logic       wr_sr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] env_level;

  always #10 clk = ~clk;

  adsr_env_core uut (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wr_ad     (wr_ad),
    .wr_sr     (wr_sr),
    .wr_data   (wr_data),
    .env_level (env_level)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;
  string cur_tag  = "R10";

  int    exp_q[$];
  string tag_q[$];

  int per_tab[16] = '{9, 32, 63, 95, 149, 220, 267, 313,
                      392, 977, 1954, 3126, 3907, 11720, 19532, 31251};

  // Reference state: phase 0 attack, 1 decay-sustain, 2 release.
  int m_cnt, m_exp, m_lvl, m_ph, m_hold, m_gate, m_att, m_dec, m_sus, m_rel;

  function automatic int div_of(int l);
    if (l == 0)  return 1;
    if (l <= 6)  return 30;
    if (l <= 14) return 16;
    if (l <= 26) return 8;
    if (l <= 54) return 4;
    if (l <= 93) return 2;
    return 1;
  endfunction

  function automatic int per_now();
    if (m_ph == 0) return per_tab[m_att];
    if (m_ph == 1) return per_tab[m_dec];
    return per_tab[m_rel];
  endfunction

  function automatic bit step_next();
    if (((m_cnt + 1) % 65536) != per_now()) return 1'b0;
    if (m_ph == 0) return 1'b1;
    return (m_exp + 1) == div_of(m_lvl);
  endfunction

  // Driver side of the scoreboard: predict and queue the level after each edge.
  always @(posedge clk) begin
    int ncnt, nexp, nlvl, nph, nhold;
    bit hit, ok, rise, fall;
    if (rst) begin
      m_cnt = 0; m_exp = 0; m_lvl = 0; m_ph = 2; m_hold = 1; m_gate = 0;
      m_att = 0; m_dec = 0; m_sus = 0; m_rel = 0;
    end else begin
      hit  = ((m_cnt + 1) % 65536) == per_now();
      ncnt = hit ? 0 : (m_cnt + 1) % 65536;
      ok   = 1'b0;
      nexp = m_exp;
      if (hit) begin
        if (m_ph == 0 || (m_exp + 1) == div_of(m_lvl)) begin
          ok = 1'b1; nexp = 0;
        end else begin
          nexp = m_exp + 1;
        end
      end
      nlvl = m_lvl; nph = m_ph; nhold = m_hold;
      if (ok && m_hold == 0) begin
        if (m_ph == 0) begin
          if (m_lvl < 255) nlvl = m_lvl + 1;
          if (nlvl == 255) nph = 1;
        end else if (m_lvl == 0) begin
          nhold = 1;
        end else if (!(m_ph == 1 && m_lvl == m_sus * 17)) begin
          nlvl = m_lvl - 1;
          if (nlvl == 0) nhold = 1;
        end
      end
      rise = wr_ctl && wr_data[0] && m_gate == 0;
      fall = wr_ctl && !wr_data[0] && m_gate == 1;
      if (rise) begin nph = 0; nhold = 0; end
      else if (fall) nph = 2;
      if (wr_ctl) m_gate = int'(wr_data[0]);
      if (wr_ad) begin m_att = int'(wr_data[7:4]); m_dec = int'(wr_data[3:0]); end
      if (wr_sr) begin m_sus = int'(wr_data[7:4]); m_rel = int'(wr_data[3:0]); end
      m_cnt = ncnt; m_exp = nexp; m_lvl = nlvl; m_ph = nph; m_hold = nhold;
    end
    exp_q.push_back(m_lvl);
    tag_q.push_back(cur_tag);
  end

  // Monitor side: pop and compare away from the active edge.
  always @(negedge clk) begin
    int    e;
    string t;
    if (exp_q.size() > 0 && !finished) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (int'(env_level) != e) begin
        n_fail++;
        $display("FAIL %s trace: level actual=%0d expected=%0d at %0t", t, env_level, e, $time);
      end
    end
  end

  task automatic check_eq(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 control, 1 attack/decay, 2 sustain/release
  task automatic wr(input int which, input logic [7:0] d);
    wr_data = d;
    wr_ctl  = (which == 0);
    wr_ad   = (which == 1);
    wr_sr   = (which == 2);
    @(negedge clk);
    wr_ctl = 1'b0; wr_ad = 1'b0; wr_sr = 1'b0;
  endtask

  task automatic wait_change(input int limit, output int n);
    int start;
    start = int'(env_level);
    n = 0;
    while (int'(env_level) == start && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, old;
    tick(3);
    rst = 1'b0;
    tick(1);
    check_eq("R10 level after reset", int'(env_level), 0);

    cur_tag = "R7";
    wr(0, 8'hFE);               // gate stays 0: no effect
    tick(50);
    check_eq("R6 R7 held at zero without gate", int'(env_level), 0);

    cur_tag = "R9";
    wr(1, 8'h00);
    wr(2, 8'h80);
    cur_tag = "R4";
    wr(0, 8'hF1);               // upper bits ignored, gate rises
    tick(4000);
    check_eq("R5 R9 settles at sustain 0x88", int'(env_level), 8'h88);

    cur_tag = "R3";
    wr(0, 8'h00);
    tick(8000);
    check_eq("R6 release reaches zero", int'(env_level), 0);

    // R11: gate drop on the very clock of an attack step
    cur_tag = "R11";
    wr(0, 8'h01);
    while (!(m_lvl >= 16 && step_next())) @(negedge clk);
    old = m_lvl;
    wr(0, 8'h00);
    check_eq("R11 step of old attack phase kept", int'(env_level), old + 1);
    wait_change(2000, n);
    check_eq("R11 next step falls after drop", int'(env_level), old);

    // R11: gate rise on the very clock of the final release step
    while (!(m_lvl == 1 && m_ph == 2 && step_next())) @(negedge clk);
    wr(0, 8'h01);
    check_eq("R11 release step to zero kept", int'(env_level), 0);
    wait_change(200, n);
    check_eq("R11 lock clear, attack resumes", int'(env_level), 1);

    cur_tag = "R12";
    wr(2, 8'h00);
    tick(12000);
    check_eq("R12 decay to zero with gate high", int'(env_level), 0);
    tick(500);
    check_eq("R12 stays locked at zero", int'(env_level), 0);

    cur_tag = "R2";
    wr(0, 8'h00);
    wr(1, 8'h40);
    wr(0, 8'h01);
    wait_change(1000, n);
    wait_change(1000, n);
    check_eq("R2 attack rate 4 step interval", n, 149);

    cur_tag = "R8";
    wr(1, 8'h30);
    wait_change(1000, n);
    check_eq("R8 new attack rate 3 interval", n + 1, 95);

    cur_tag = "R1";
    wr(1, 8'h10);
    wait_change(1000, n);
    tick(20);
    old = int'(env_level);
    wr(1, 8'h00);               // period drops below the running count
    tick(60000);
    check_eq("R1 no step while counter wraps", int'(env_level), old);
    wait_change(10000, n);
    check_eq("R1 step after 16-bit wrap", int'(env_level), old + 1);

    tick(2);
    finish_run();
  end

endmodule